// File: doc/BRIEF.md
# Bus-Mapped Eight-Pin GPIO Port with Data-Bus Takeover

This block is an eight-pin general-purpose port on a simple peripheral register bus. Software uses three registers. A direction register chooses, pin by pin, between driving and sensing. An output register holds the values that driven pins present. A pin-view register reports the synchronised level seen at each pad. Two of the three addresses are shared with a neighbouring port, and their read and write meanings differ. A write to the direction address lands here, but a read of it returns the neighbour's pins. A write to the pin-view address is passed on as a write strobe for the neighbour's direction register, while a read of it returns this port's own pads.

When the chip runs in an expanded mode with expansion enabled and the narrow-bus control bit cleared, the block hands all eight pads to the external bus controller as data lines, whatever the direction register holds. With the control bit set, the pins behave as an ordinary port again. The block also handles three power states. Hardware standby clears the direction and output registers. Software standby keeps both registers. In either standby the data-bus lines float.

Top module: `gpio8_busport`

## Requirements
- R1: After reset the direction register is 0x00 and every pad is undriven. A direction bit of 1 drives its pad (pad_oe bit 1) and a 0 releases it, outside bus takeover.
- R2: Hardware standby clears the direction and output registers and releases every pad. Software standby keeps both registers and the port-mode pad drive unchanged. Bus writes are ignored while either standby is active.
- R3: The output register (default address 0xFFBC) is readable and writable, resets to 0x00, and supplies pad_out outside bus takeover.
- R4: Writing the direction address (default 0xFFBE) updates the direction register. Reading that address returns nbr_pins, not the direction bits.
- R5: Writing the pin-view address (default 0xFFBD) raises nbr_dir_we in the same cycle with nbr_dir_wdata equal to the write data, and leaves this port's registers unchanged. Reading that address returns pad_in as it stood two clock edges earlier.
- R6: When mode_expanded=1, ext_en=1 and narrow_bus=0, all eight pad_oe bits equal xbus_oe, pad_out equals xbus_out, and xbus_in equals pad_in, whatever the direction register holds.
- R7: When mode_expanded=1, ext_en=1 and narrow_bus=1, the pads follow the direction and output registers exactly as in single-chip mode, and xbus_in reads 0x00.
- R8: During bus takeover the pads are undriven while reset, hardware standby or software standby is active.
- R9: Reads of any other address return 0x00. Writes to any other address change nothing.
- R10: A pin set as an output reads back its own driven value through the pin-view register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| mode_expanded | input | 1 | Chip is in an expanded bus mode |
| ext_en | input | 1 | External expansion enable |
| narrow_bus | input | 1 | Bus-width control bit; 0 hands pads to the data bus |
| bus_addr | input | 16 | Low 16 bits of the register address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| nbr_pins | input | 8 | Neighbouring port's pin states |
| nbr_dir_we | output | 1 | Write strobe for the neighbour's direction register |
| nbr_dir_wdata | output | 8 | Data for the neighbour's direction register |
| xbus_out | input | 8 | Data from the bus controller for the pads |
| xbus_oe | input | 1 | Bus controller drive request |
| xbus_in | output | 8 | Pad data returned to the bus controller |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_in | input | 8 | Resolved pad levels |

## Verification
On every cycle the assertions check the following. Hardware standby releases every pad. Software standby leaves the direction register unchanged. A write to the shared pin-view address leaves local state untouched. Bus takeover drives the pads all together or not at all, and never during standby. The address aliasing, the two-edge latency of the pin view, the readback of outputs through the modelled pads and the switch between bus widths only show up in the bench's scenarios. There, a behavioural model runs alongside the design and is compared with it on every clock.

// File: rtl/gpio8_busport.sv
module gpio8_busport #(
  parameter int          W        = 8,
  parameter int          AW       = 16,
  parameter logic [15:0] A_OUT    = 16'hFFBC,
  parameter logic [15:0] A_PINS   = 16'hFFBD,
  parameter logic [15:0] A_DIR    = 16'hFFBE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          sw_stby,
  input  logic          mode_expanded,
  input  logic          ext_en,
  input  logic          narrow_bus,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  nbr_pins,
  output logic          nbr_dir_we,
  output logic [W-1:0]  nbr_dir_wdata,
  input  logic [W-1:0]  xbus_out,
  input  logic          xbus_oe,
  output logic [W-1:0]  xbus_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  input  logic [W-1:0]  pad_in
);

  logic [W-1:0] dir_q, out_q, sync1_q, sync2_q;
  logic         stby, wr_ok, bus_mode, bus_drive;

  assign stby      = hw_stby | sw_stby;
  assign wr_ok     = bus_wr & ~stby;
  assign bus_mode  = mode_expanded & ext_en & ~narrow_bus;
  assign bus_drive = xbus_oe & ~stby & rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (hw_stby) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_ok) begin
      if (bus_addr == A_DIR[AW-1:0]) dir_q <= bus_wdata;
      if (bus_addr == A_OUT[AW-1:0]) out_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    if (bus_addr == A_DIR[AW-1:0])       bus_rdata = nbr_pins;
    else if (bus_addr == A_OUT[AW-1:0])  bus_rdata = out_q;
    else if (bus_addr == A_PINS[AW-1:0]) bus_rdata = sync2_q;
    else                                 bus_rdata = '0;
  end

  assign nbr_dir_we    = wr_ok & (bus_addr == A_PINS[AW-1:0]);
  assign nbr_dir_wdata = bus_wdata;

  assign pad_oe  = bus_mode ? {W{bus_drive}} : (hw_stby ? '0 : dir_q);
  assign pad_out = bus_mode ? xbus_out : out_q;
  assign xbus_in = bus_mode ? pad_in : '0;

  a_r2_hw_release: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> pad_oe == '0);

  a_r2_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> $stable(dir_q));

  a_r5_alias_no_local: assert property (@(posedge clk) disable iff (!rst_n)
    (nbr_dir_we && !hw_stby) |=> ($stable(dir_q) && $stable(out_q)));

  a_r6_bus_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    bus_mode |-> (pad_oe == '0 || pad_oe == '1));

  a_r8_bus_float: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_mode && stby) |-> pad_oe == '0);

  a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !hw_stby && bus_addr == A_OUT[AW-1:0]) |=> out_q == $past(bus_wdata));

endmodule

// File: tb/gpio8_busport_bench.sv
module gpio8_busport_bench;
  logic clk = 0, rst_n = 0, hw_stby = 0, sw_stby = 0;
  logic mode_expanded = 0, ext_en = 0, narrow_bus = 0;
  logic [15:0] bus_addr = 16'h0000;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, nbr_pins = 8'h00;
  logic nbr_dir_we;
  logic [7:0] nbr_dir_wdata, xbus_out = 8'h00, xbus_in, pad_out, pad_oe, pad_in;
  logic xbus_oe = 0;
  logic [7:0] ext_lvl = 8'h00;
  int checks = 0, failures = 0, cyc = 0;
  logic done = 0;

  always #10 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_pad
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext_lvl[i];
  end

  gpio8_busport u_gpio8_busport (.*);

  logic [7:0] m_dir = 0, m_out = 0, m_s1 = 0, m_s2 = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir <= 0; m_out <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      m_s1 <= pad_in; m_s2 <= m_s1;
      if (hw_stby) begin m_dir <= 0; m_out <= 0; end
      else if (!sw_stby && bus_wr) begin
        if (bus_addr == 16'hFFBE) m_dir <= bus_wdata;
        if (bus_addr == 16'hFFBC) m_out <= bus_wdata;
      end
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done) begin
      logic stby, bm;
      logic [7:0] e_oe, e_out, e_rd;
      stby = hw_stby | sw_stby;
      bm = mode_expanded & ext_en & ~narrow_bus;
      e_oe  = bm ? ((xbus_oe && !stby && rst_n) ? 8'hFF : 8'h00) : (hw_stby ? 8'h00 : m_dir);
      e_out = bm ? xbus_out : m_out;
      if (bm) check(stby ? "R8 pad_oe" : "R6 pad_oe", pad_oe, e_oe);
      else    check(hw_stby ? "R2 pad_oe" : (mode_expanded ? "R7 pad_oe" : "R1 pad_oe"), pad_oe, e_oe);
      check(bm ? "R6 pad_out" : "R3 pad_out", pad_out, e_out);
      check(bm ? "R6 xbus_in" : "R7 xbus_in", xbus_in, bm ? pad_in : 8'h00);
      case (bus_addr)
        16'hFFBE: begin e_rd = nbr_pins; check("R4 rdata", bus_rdata, e_rd); end
        16'hFFBC: begin e_rd = m_out;    check("R3 rdata", bus_rdata, e_rd); end
        16'hFFBD: begin e_rd = m_s2;     check("R5 rdata", bus_rdata, e_rd); end
        default:  begin e_rd = 8'h00;    check("R9 rdata", bus_rdata, e_rd); end
      endcase
      check("R5 nbr_we", {7'd0, nbr_dir_we}, {7'd0, bus_wr && !stby && bus_addr == 16'hFFBD});
      if (nbr_dir_we) check("R5 nbr_data", nbr_dir_wdata, bus_wdata);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_check(string tag, logic [15:0] a, logic [7:0] exp);
    @(negedge clk); bus_addr = a;
    #3 check(tag, bus_rdata, exp);
  endtask

  initial begin
    fork
      begin
        while (cyc < 20000) begin @(posedge clk); cyc++; end
        failures++;
        $display("FAIL watchdog expired");
      end
      begin
        tick(3);
        #3 check("R1 reset oe", pad_oe, 8'h00);
        rst_n = 1;
        rd_check("R3 reset out", 16'hFFBC, 8'h00);
        ext_lvl = 8'h96; nbr_pins = 8'h3C;
        wr(16'hFFBE, 8'h0F);
        wr(16'hFFBC, 8'hA5);
        rd_check("R4 dir alias", 16'hFFBE, 8'h3C);
        rd_check("R3 out read", 16'hFFBC, 8'hA5);
        tick(3);
        rd_check("R10 readback", 16'hFFBD, 8'h95);
        wr(16'hFFBD, 8'h77);
        #3 check("R5 alias keeps dir", pad_oe, 8'h0F);
        wr(16'h1234, 8'hFF);
        rd_check("R9 unmapped", 16'h1234, 8'h00);
        #3 check("R9 no effect", pad_oe, 8'h0F);
        ext_lvl = 8'h5A; tick(4);
        sw_stby = 1;
        wr(16'hFFBE, 8'hF0);
        tick(2);
        #3 check("R2 sw keeps dir", pad_oe, 8'h0F);
        sw_stby = 0; hw_stby = 1; tick(2);
        #3 check("R2 hw release", pad_oe, 8'h00);
        hw_stby = 0;
        rd_check("R2 hw clears out", 16'hFFBC, 8'h00);
        wr(16'hFFBE, 8'hC3); wr(16'hFFBC, 8'h81);
        mode_expanded = 1; ext_en = 1; narrow_bus = 0;
        xbus_out = 8'h6E; xbus_oe = 1; tick(2);
        #3 check("R6 bus drive", pad_oe, 8'hFF);
        check("R6 bus data", pad_out, 8'h6E);
        xbus_oe = 0; ext_lvl = 8'h2B; tick(1);
        #3 check("R6 bus in", xbus_in, 8'h2B);
        xbus_oe = 1; sw_stby = 1; tick(2);
        #3 check("R8 sw float", pad_oe, 8'h00);
        sw_stby = 0; hw_stby = 1; tick(1);
        #3 check("R8 hw float", pad_oe, 8'h00);
        hw_stby = 0;
        wr(16'hFFBE, 8'h3C); wr(16'hFFBC, 8'h99);
        narrow_bus = 1; tick(2);
        #3 check("R7 narrow oe", pad_oe, 8'h3C);
        check("R7 narrow out", pad_out, 8'h99);
        check("R7 narrow xin", xbus_in, 8'h00);
        narrow_bus = 0; @(negedge clk); rst_n = 0; #3 check("R8 reset float", pad_oe, 8'h00);
        tick(2); rst_n = 1;
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          narrow_bus = k[2]; ext_en = k[3]; ext_lvl = 8'(k * 37);
          bus_addr = 16'hFFBC + 16'(k % 4); bus_wdata = 8'(k * 13); bus_wr = k[0];
          nbr_pins = 8'(k * 5);
        end
        @(negedge clk); bus_wr = 0;
        tick(3);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    join_any
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule